// File: doc/BRIEF.md
# SPI Master Interrupt Aggregator

This block collects the interrupt conditions of an SPI master's datapath into one level interrupt line. It keeps three software-visible registers on a 32-bit register port: a sticky status register, a per-source enable register, and a master enable that holds a single bit. The datapath delivers two kinds of inputs. Single-cycle event pulses mark overrun, underrun, half-empty, a receive FIFO that has just filled, and the end of a transmit drain. Two FIFO level flags (receive data present, receive FIFO full) are sampled into the status only when the register port is accessed.

Software clears a pending condition by writing a one to its status bit. That write flips the bit, so a one written to a clear bit sets it. When an event arrives in the same cycle as such a write, the event wins. The interrupt line is registered. It is high while some enabled status bit is set and the master enable bit is set.

Top module: `spi_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, the master enable, status and enable registers all read as zero, `irq` is low and `reg_rdata` is zero.
- R2: Register map, byte addresses. Master enable is at 0x1C, and only bit 31 is stored. Status is at 0x20. Enable is at 0x28. Status and enable keep only the source bits 8, 6, 5, 4, 3 and 2. Unimplemented bits read as zero. Misaligned addresses and all other addresses read zero and ignore writes. `reg_rdata` carries the register value from before the access and is valid in the cycle after `reg_rd`.
- R3: A write to the status register XORs the written data into the implemented status bits.
- R4: On every cycle with `reg_rd` or `reg_wr` high, at any address, the status register is updated from the level flags. `fifo_rx_has_data` sets bit 8 and `fifo_rx_at_limit` sets bit 4. The level flags have no effect in cycles without an access.
- R5: Event pulses set sticky status bits in the cycle they are high: `evt_rx_overrun` sets bit 5, `evt_tx_underrun` sets bit 3, `evt_tx_half_empty` sets bit 6 and `evt_rx_filled` sets bit 4. Only a status write clears a bit.
- R6: `evt_drain_done` sets status bit 2 (transmit empty) and bit 8 (receive data present).
- R7: When a source sets a status bit in the same cycle that a status write would toggle it, the bit ends up set.
- R8: `irq` is registered. After each clock edge it equals the OR of (status AND enable) of the register values updated at that same edge, gated by the master enable.
- R9: While the master enable bit is clear, `irq` stays low whatever the status and enable registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| fifo_rx_has_data | input | 1 | Level: receive FIFO not empty |
| fifo_rx_at_limit | input | 1 | Level: receive FIFO full |
| evt_rx_overrun | input | 1 | Pulse: receive data dropped |
| evt_tx_underrun | input | 1 | Pulse: transmit FIFO underrun |
| evt_tx_half_empty | input | 1 | Pulse: transmit FIFO at half |
| evt_rx_filled | input | 1 | Pulse: receive FIFO just became full |
| evt_drain_done | input | 1 | Pulse: transmit drain finished |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the absence of level sampling. Any read used to observe the status is itself an access, so it samples the level flags. The stimulus therefore holds the flags high through several idle cycles, drops them, and only then reads, expecting no bit. It then raises them during a write to an unused address. The second hard case is a read in the same cycle as the sampling: it must still return the old value, and the new bit must appear only on the next read. The collision of an event with a toggle write is driven by pulsing the event in the exact cycle of the status write.

// File: rtl/spi_irq_agg_pkg.sv
// Package: shared constants and types for the SPI interrupt aggregator.
// Assumes a 32-bit register port; bit positions are software visible.
package spi_irq_agg_pkg;

    localparam int DATA_W = 32;

    // Status / enable source bit positions (decoded by software)
    localparam int BIT_TX_EMPTY = 2;
    localparam int BIT_TX_UND   = 3;
    localparam int BIT_RX_FULL  = 4;
    localparam int BIT_RX_OVR   = 5;
    localparam int BIT_TX_HALF  = 6;
    localparam int BIT_RX_HAS   = 8;

    // Master enable bit inside its register
    localparam int GIE_BIT = DATA_W - 1;

    // Byte offsets of the registers
    localparam int OFS_GIE  = 'h1C;
    localparam int OFS_STAT = 'h20;
    localparam int OFS_ENA  = 'h28;

    localparam logic [DATA_W-1:0] SRC_MASK =
        (DATA_W'(1) << BIT_TX_EMPTY) | (DATA_W'(1) << BIT_TX_UND)  |
        (DATA_W'(1) << BIT_RX_FULL)  | (DATA_W'(1) << BIT_RX_OVR)  |
        (DATA_W'(1) << BIT_TX_HALF)  | (DATA_W'(1) << BIT_RX_HAS);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_GIE,
        SEL_STAT,
        SEL_ENA
    } reg_sel_e;

    typedef struct packed {
        logic rx_ovr;
        logic tx_und;
        logic tx_half;
        logic rx_filled;
        logic drain;
    } evt_s;

endpackage

// File: rtl/spi_irq_agg_regif.sv
// Module: register port decode, enable and master-enable storage, read mux.
// Assumes word-aligned accesses; misaligned or unknown addresses hit nothing.
// Read data is registered and shows the value from before the access.
module spi_irq_agg_regif
    import spi_irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] status_q,
    output logic              access,
    output logic              st_wr,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] en_nxt,
    output logic              gie_q,
    output logic              gie_nxt,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;

    // Address decode into a register select
    always_comb begin
        sel = SEL_NONE;
        if (reg_addr == ADDR_W'(OFS_GIE))       sel = SEL_GIE;
        else if (reg_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
        else if (reg_addr == ADDR_W'(OFS_ENA))  sel = SEL_ENA;
    end

    assign access = reg_wr | reg_rd;
    assign st_wr  = reg_wr && (sel == SEL_STAT);

    // Next values of the enable and master-enable registers
    always_comb begin
        en_nxt  = en_q;
        gie_nxt = gie_q;
        if (reg_wr && sel == SEL_ENA) en_nxt  = reg_wdata & SRC_MASK;
        if (reg_wr && sel == SEL_GIE) gie_nxt = reg_wdata[GIE_BIT];
    end

    // Enable and master-enable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else begin
            en_q  <= en_nxt;
            gie_q <= gie_nxt;
        end
    end

    // Read multiplexer over the current register values
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_GIE:  rd_mux[GIE_BIT] = gie_q;
            SEL_STAT: rd_mux = status_q;
            SEL_ENA:  rd_mux = en_q;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, updated only on a read
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    AST_RD_ENA: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel == SEL_ENA) |=> (reg_rdata == $past(en_q))); // R2
    AST_GIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && sel == SEL_GIE) |=> $stable(gie_q)); // R2

endmodule

// File: rtl/spi_irq_agg_status.sv
// Module: sticky status register with toggle-on-write.
// Assumes event pulses are one cycle long and synchronous to clk.
// Sets from events and sampled levels win over a toggle in the same cycle.
module spi_irq_agg_status
    import spi_irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              st_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lvl_rx_has,
    input  logic              lvl_rx_full,
    input  evt_s              evt,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] status_nxt
);

    logic [DATA_W-1:0] set_vec;

    // Collect all set requests for this cycle
    always_comb begin
        set_vec = '0;
        set_vec[BIT_RX_OVR]   = evt.rx_ovr;
        set_vec[BIT_TX_UND]   = evt.tx_und;
        set_vec[BIT_TX_HALF]  = evt.tx_half;
        set_vec[BIT_RX_FULL]  = evt.rx_filled | (access & lvl_rx_full);
        set_vec[BIT_TX_EMPTY] = evt.drain;
        set_vec[BIT_RX_HAS]   = evt.drain | (access & lvl_rx_has);
    end

    // Per-bit next state: implemented bits toggle or set, others tie low
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (SRC_MASK[i]) begin : g_live
            assign status_nxt[i] = set_vec[i] |
                (st_wr ? (status_q[i] ^ wdata[i]) : status_q[i]);
        end else begin : g_tied
            assign status_nxt[i] = 1'b0;
        end
    end

    // Status register storage
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((status_q & $past(status_q)) == $past(status_q))); // R5
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && set_vec == '0) |=>
        (status_q == ($past(status_q) ^ ($past(wdata) & SRC_MASK)))); // R3
    AST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (access && lvl_rx_has) |=> status_q[BIT_RX_HAS]); // R4

endmodule

// File: rtl/spi_irq_agg_line.sv
// Module: registered interrupt line generation.
// Assumes the next-state register values are presented, so the line
// updates at the same edge as the registers it depends on.
module spi_irq_agg_line
    import spi_irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_nxt,
    input  logic [DATA_W-1:0] en_nxt,
    input  logic              gie_nxt,
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] en_q,
    input  logic              gie_q,
    output logic              irq
);

    // Interrupt flop: masked, enabled pending sources
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= gie_nxt & (|(status_nxt & en_nxt));
    end

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (gie_q && ((status_q & en_q) != '0))); // R8
    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !irq); // R9

endmodule

// File: rtl/spi_irq_agg.sv
// Module: top of the SPI master interrupt aggregator.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module spi_irq_agg
    import spi_irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fifo_rx_has_data,
    input  logic              fifo_rx_at_limit,
    input  logic              evt_rx_overrun,
    input  logic              evt_tx_underrun,
    input  logic              evt_tx_half_empty,
    input  logic              evt_rx_filled,
    input  logic              evt_drain_done,
    output logic              irq
);

    logic              access;
    logic              st_wr;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] en_nxt;
    logic              gie_q;
    logic              gie_nxt;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] status_nxt;
    evt_s              evt;

    // Bundle the event pulses
    always_comb begin
        evt.rx_ovr    = evt_rx_overrun;
        evt.tx_und    = evt_tx_underrun;
        evt.tx_half   = evt_tx_half_empty;
        evt.rx_filled = evt_rx_filled;
        evt.drain     = evt_drain_done;
    end

    spi_irq_agg_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_q  (status_q),
        .access    (access),
        .st_wr     (st_wr),
        .en_q      (en_q),
        .en_nxt    (en_nxt),
        .gie_q     (gie_q),
        .gie_nxt   (gie_nxt),
        .reg_rdata (reg_rdata)
    );

    spi_irq_agg_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .access      (access),
        .st_wr       (st_wr),
        .wdata       (reg_wdata),
        .lvl_rx_has  (fifo_rx_has_data),
        .lvl_rx_full (fifo_rx_at_limit),
        .evt         (evt),
        .status_q    (status_q),
        .status_nxt  (status_nxt)
    );

    spi_irq_agg_line u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_nxt (status_nxt),
        .en_nxt     (en_nxt),
        .gie_nxt    (gie_nxt),
        .status_q   (status_q),
        .en_q       (en_q),
        .gie_q      (gie_q),
        .irq        (irq)
    );

endmodule

// File: tb/spi_irq_agg_tb.sv
`timescale 1ns/1ps
module spi_irq_agg_tb;

    localparam logic [31:0] MASK = 32'h0000_017C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        lv_has, lv_full;
    logic        e_ovr, e_und, e_half, e_fill, e_drain;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic [31:0] m_st = '0, m_en = '0;
    logic        m_gie = 1'b0;

    // Scoreboard queues for read results
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    spi_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_rx_has_data(lv_has), .fifo_rx_at_limit(lv_full),
        .evt_rx_overrun(e_ovr), .evt_tx_underrun(e_und),
        .evt_tx_half_empty(e_half), .evt_rx_filled(e_fill),
        .evt_drain_done(e_drain), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops an expected read value one edge after a read strobe
    logic rd_fire;
    always @(posedge clk) begin
        rd_fire = reg_rd;
        #1;
        if (rd_fire && rst_n) begin
            if (exp_q.size() == 0) check("scoreboard", 32'h1, 32'h0);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h1C:   return {m_gie, 31'b0};
            8'h20:   return m_st;
            8'h28:   return m_en;
            default: return 32'h0;
        endcase
    endfunction

    // Driver: one cycle of stimulus; ev = {drain, filled, half, und, ovr}
    task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [31:0] d, input logic [4:0] ev,
                        input logic lh, input logic lf, input string req);
        logic [31:0] setv;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        lv_has = lh; lv_full = lf;
        {e_drain, e_fill, e_half, e_und, e_ovr} = ev;
        if (rd) begin
            exp_q.push_back(model_read(a));
            tag_q.push_back(req);
        end
        setv = '0;
        setv[5] = ev[0];
        setv[3] = ev[1];
        setv[6] = ev[2];
        setv[4] = ev[3] | ((wr | rd) & lf);
        setv[2] = ev[4];
        setv[8] = ev[4] | ((wr | rd) & lh);
        m_st = setv | ((wr && a == 8'h20) ? (m_st ^ (d & MASK)) : m_st);
        if (wr && a == 8'h28) m_en  = d & MASK;
        if (wr && a == 8'h1C) m_gie = d[31];
        @(posedge clk);
        #1;
        check({req, " irq"}, {31'b0, irq}, {31'b0, m_gie & (|(m_st & m_en))});
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string req);
        step(1'b1, 1'b0, a, d, 5'b0, 1'b0, 1'b0, req);
    endtask
    task automatic rd_reg(input logic [7:0] a, input string req);
        step(1'b0, 1'b1, a, 32'h0, 5'b0, 1'b0, 1'b0, req);
    endtask
    task automatic pulse(input logic [4:0] ev, input string req);
        step(1'b0, 1'b0, 8'h00, 32'h0, ev, 1'b0, 1'b0, req);
    endtask

    // Watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        lv_has = 0; lv_full = 0; {e_drain, e_fill, e_half, e_und, e_ovr} = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        check("R1 rdata in reset", reg_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_reg(8'h1C, "R1 gie");
        rd_reg(8'h20, "R1 status");
        rd_reg(8'h28, "R1 enable");

        // R2: map and masking
        wr_reg(8'h28, 32'hFFFF_FFFF, "R2");
        rd_reg(8'h28, "R2 enable mask");
        wr_reg(8'h1C, 32'h7FFF_FFFF, "R2");
        rd_reg(8'h1C, "R2 gie low bits");
        wr_reg(8'h1C, 32'hFFFF_FFFF, "R2");
        rd_reg(8'h1C, "R2 gie bit31");
        wr_reg(8'h24, 32'hFFFF_FFFF, "R2");
        rd_reg(8'h24, "R2 unused addr");
        wr_reg(8'h29, 32'h0, "R2");
        rd_reg(8'h28, "R2 misaligned write");
        rd_reg(8'h21, "R2 misaligned read");

        // R5: event sets sticky bit, R8 irq follows
        pulse(5'b00001, "R5 overrun R8");
        rd_reg(8'h20, "R5 overrun bit");

        // R3: toggle on write
        wr_reg(8'h20, 32'h0000_0020, "R3 clear");
        rd_reg(8'h20, "R3 cleared");
        wr_reg(8'h20, 32'h0000_000C, "R3 set");
        rd_reg(8'h20, "R3 toggled on");
        wr_reg(8'h20, 32'hFFFF_FFFF, "R3 all");
        rd_reg(8'h20, "R3 toggled all");
        wr_reg(8'h20, 32'h0000_0170, "R3");
        rd_reg(8'h20, "R3 zero");

        // R4: levels ignored without access
        repeat (3) step(1'b0, 1'b0, 8'h00, 32'h0, 5'b0, 1'b1, 1'b1, "R4 idle");
        rd_reg(8'h20, "R4 no access no sample");
        step(1'b1, 1'b0, 8'h30, 32'h0, 5'b0, 1'b1, 1'b0, "R4 sample on write");
        rd_reg(8'h20, "R4 has-data bit");
        step(1'b0, 1'b1, 8'h20, 32'h0, 5'b0, 1'b0, 1'b1, "R4 read old value");
        rd_reg(8'h20, "R4 full bit");
        wr_reg(8'h20, 32'h0000_0110, "R4");

        // R5: more sources, stickiness
        pulse(5'b01100, "R5 half+filled");
        repeat (4) pulse(5'b0, "R5 idle");
        rd_reg(8'h20, "R5 sticky");
        wr_reg(8'h20, 32'h0000_0050, "R5");

        // R6: drain completion
        pulse(5'b10000, "R6 drain");
        rd_reg(8'h20, "R6 drain bits");
        wr_reg(8'h20, 32'h0000_0104, "R6");

        // R7: set wins over toggle
        pulse(5'b00010, "R7 underrun");
        step(1'b1, 1'b0, 8'h20, 32'h0000_0008, 5'b00010, 1'b0, 1'b0, "R7 collide");
        rd_reg(8'h20, "R7 bit kept");
        wr_reg(8'h20, 32'h0000_0008, "R3 plain clear");
        rd_reg(8'h20, "R3 cleared again");

        // R8 / R9: masking
        pulse(5'b00001, "R8 pending");
        wr_reg(8'h28, 32'h0000_0008, "R8 masked off");
        wr_reg(8'h28, 32'h0000_0020, "R8 unmasked");
        wr_reg(8'h1C, 32'h0, "R9 gie off");
        pulse(5'b00010, "R9 still low");
        wr_reg(8'h28, 32'hFFFF_FFFF, "R9 all enabled");
        wr_reg(8'h1C, 32'h8000_0000, "R9 gie on");
        rd_reg(8'h1C, "R9 gie readback");

        pulse(5'b0, "end");
        pulse(5'b0, "end");
        if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule